// File: doc/BRIEF.md
# I2C Bus Condition and Arbitration Monitor

This block listens to the two lines of an I2C bus and turns what it sees into single-cycle event pulses for a bus controller. Both raw line samples first pass a synchronizer and a glitch filter. The filtered lines are then decoded into START, repeated START and STOP conditions. From these conditions the block keeps a bus-busy flag and a position counter inside the current nine-clock frame.

The counter lets the block flag a START or STOP that lands where a data bit belongs as a bus error. While the device is the master that opened the transfer, the block also compares the level it is driving on SDA against the line on every rising SCL edge. On a mismatch it reports lost arbitration and tells the controller to let go of both lines.

Condition decoding runs directly on the system clock and has no enable input. It therefore keeps running while the rest of the chip sleeps, and it raises a wake request on every START.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A line change reaches the decoder only after the synchronized sample has shown the new level for FILT_CYC consecutive clock cycles (default 4). A shorter pulse on either line is dropped and produces no event.
- R2: SDA falling while SCL is high, with the bus idle, gives a one-cycle `ev_start` pulse and sets `bus_busy`. After reset `bus_busy` is 0 and every event output is 0.
- R3: SDA falling while SCL is high, with `bus_busy` already set, gives a one-cycle `ev_rstart` pulse and no `ev_start`. `bus_busy` stays set.
- R4: SDA rising while SCL is high gives a one-cycle `ev_stop` pulse and clears `bus_busy`.
- R5: Arbitration is evaluated only while `own_master` is 1. With `own_master` at 0, `arb_lost` stays 0 whatever the lines and the drive value do.
- R6: On a filtered SCL rising edge, if `own_master` is 1, `sda_drive` is 1 and filtered SDA is 0, `arb_lost` pulses for exactly one cycle. `release_bus` then rises with that pulse and stays at 1 until `own_master` goes to 0. A matching drive and line level gives no loss.
- R7: The frame position resets to 0 on every condition and counts filtered SCL rising edges. The count wraps from 9 back to 1. A START or STOP seen while busy at position 2 to 9 pulses `bus_error`, and the condition itself is still reported. At position 0 or 1 it is legal.
- R8: While busy and `own_master` is 1, a START seen while the device releases SDA (`sda_drive` = 1) is an undecidable collision. It pulses `bus_error` and `ev_rstart` and does not pulse `arb_lost`.
- R9: `wake_req` pulses for one cycle on every START and every repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_raw | input | 1 | Unfiltered SCL sample |
| sda_raw | input | 1 | Unfiltered SDA sample |
| sda_drive | input | 1 | Level this device drives on SDA (1 = released) |
| own_master | input | 1 | This device opened the current transfer as master |
| ev_start | output | 1 | START on an idle bus, one-cycle pulse |
| ev_rstart | output | 1 | START on a busy bus, one-cycle pulse |
| ev_stop | output | 1 | STOP, one-cycle pulse |
| bus_busy | output | 1 | Bus held between START and STOP |
| bus_error | output | 1 | Misplaced or colliding condition, one-cycle pulse |
| arb_lost | output | 1 | Arbitration lost, one-cycle pulse |
| release_bus | output | 1 | Controller must free SDA and stop clocking SCL |
| wake_req | output | 1 | Wake request on any START, one-cycle pulse |

## Verification
The bench sweeps SDA glitch widths from 1 to 6 cycles on an idle bus. A filter that is off by one cycle would accept a 3-cycle spike or drop a 4-cycle pulse, and the START and STOP counts would no longer follow the width. It then places a STOP at each frame position from 1 to 10. An error flag tied to the wrong counter phase, or a counter that fails to wrap after nine clocks, would misreport the legal positions 1 and 10 or miss the illegal ones.

Arbitration runs are repeated with and without `own_master`, with matching and mismatching levels, and against a foreign START during a released data bit. A checker that samples over the whole high phase, or that gives arbitration priority over collisions, would emit a stray or repeated `arb_lost` in these runs.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

   typedef struct packed {
      logic start;
      logic rstart;
      logic stop;
      logic error;
      logic wake;
   } bus_evt_t;

   function automatic int unsigned pos_width(input int unsigned frame_bits);
      return $clog2(frame_bits + 1);
   endfunction

endpackage

// File: rtl/i2cmon_line_filter.sv
module i2cmon_line_filter #(
   parameter int unsigned FILT_CYC    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        RST_LVL     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic filt
);
   localparam int unsigned CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

   logic s_line;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign s_line = raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= {SYNC_STAGES{RST_LVL}};
            end else begin
               sync_q[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sync_q[i] <= sync_q[i-1];
               end
            end
         end
         assign s_line = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   generate
      if (FILT_CYC <= 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt <= RST_LVL;
            else        filt <= s_line;
         end
      end else begin : g_count
         logic [CNT_W-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               filt  <= RST_LVL;
            end else if (s_line == filt) begin
               run_q <= '0;
            end else if (run_q == CNT_W'(FILT_CYC - 1)) begin
               run_q <= '0;
               filt  <= s_line;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (filt != $past(filt)) |-> ($past(s_line) == filt)); // R1

endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
   import i2cmon_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 9
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_f,
   input  logic     sda_f,
   input  logic     own_master,
   input  logic     sda_drive,
   output logic     scl_rise,
   output logic     busy,
   output bus_evt_t evt
);
   localparam int unsigned POS_W = pos_width(FRAME_BITS);

   logic             scl_q, sda_q;
   logic [POS_W-1:0] pos_q;
   logic             start_c, stop_c, mid_frame, collide, err_c;

   assign scl_rise  = scl_f & ~scl_q;
   assign start_c   = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_c    = scl_f & scl_q & ~sda_q & sda_f;
   assign mid_frame = busy && (pos_q >= POS_W'(2));
   assign collide   = start_c & busy & own_master & sda_drive;
   assign err_c     = ((start_c | stop_c) & mid_frame) | collide;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
         pos_q <= '0;
         busy  <= 1'b0;
         evt   <= '0;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
         if (start_c || stop_c) begin
            pos_q <= '0;
         end else if (scl_rise) begin
            pos_q <= (pos_q == POS_W'(FRAME_BITS)) ? POS_W'(1) : pos_q + 1'b1;
         end
         if (start_c)     busy <= 1'b1;
         else if (stop_c) busy <= 1'b0;
         evt.start  <= start_c & ~busy;
         evt.rstart <= start_c & busy;
         evt.stop   <= stop_c;
         evt.error  <= err_c;
         evt.wake   <= start_c;
      end
   end

   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      evt.start |-> busy); // R2
   AST_BUSY_ONLY_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> evt.start); // R2
   AST_RSTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      evt.rstart |-> ($past(busy) && busy)); // R3
   AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stop |-> !busy); // R4
   AST_ERR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      evt.error |-> $past(busy)); // R7
   AST_ERR_WITH_COND: assert property (@(posedge clk) disable iff (!rst_n)
      evt.error |-> (evt.rstart || evt.stop)); // R8
   AST_WAKE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      evt.wake |-> (evt.start || evt.rstart)); // R9

endmodule

// File: rtl/i2cmon_arb_check.sv
module i2cmon_arb_check (
   input  logic clk,
   input  logic rst_n,
   input  logic own_master,
   input  logic sda_drive,
   input  logic scl_rise,
   input  logic sda_f,
   output logic arb_lost,
   output logic release_bus
);
   logic lost_now;

   assign lost_now = own_master & ~release_bus & scl_rise & sda_drive & ~sda_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arb_lost    <= 1'b0;
         release_bus <= 1'b0;
      end else begin
         arb_lost <= lost_now;
         if (!own_master)   release_bus <= 1'b0;
         else if (lost_now) release_bus <= 1'b1;
      end
   end

   AST_ARB_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> $past(own_master)); // R5
   AST_ARB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> release_bus); // R6
   AST_ARB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |=> !arb_lost); // R6
   AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (release_bus && own_master) |=> release_bus); // R6

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
   import i2cmon_pkg::*;
#(
   parameter int unsigned FILT_CYC    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FRAME_BITS  = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   input  logic sda_drive,
   input  logic own_master,
   output logic ev_start,
   output logic ev_rstart,
   output logic ev_stop,
   output logic bus_busy,
   output logic bus_error,
   output logic arb_lost,
   output logic release_bus,
   output logic wake_req
);
   localparam int unsigned N_LINES = 2;

   generate
      if (FILT_CYC < 1)    begin : g_bad_filt  $error("FILT_CYC must be at least 1"); end
      if (SYNC_STAGES > 3) begin : g_bad_sync  $error("SYNC_STAGES must be 0 to 3"); end
      if (FRAME_BITS < 2)  begin : g_bad_frame $error("FRAME_BITS must be at least 2"); end
   endgenerate

   logic [N_LINES-1:0] raw_lines, filt_lines;
   logic               scl_f, sda_f, scl_rise;
   bus_evt_t           evt;

   assign raw_lines = {sda_raw, scl_raw};

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_line
         i2cmon_line_filter #(
            .FILT_CYC   (FILT_CYC),
            .SYNC_STAGES(SYNC_STAGES),
            .RST_LVL    (1'b1)
         ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[g]),
            .filt (filt_lines[g])
         );
      end
   endgenerate

   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   i2cmon_cond_detect #(.FRAME_BITS(FRAME_BITS)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (scl_f),
      .sda_f     (sda_f),
      .own_master(own_master),
      .sda_drive (sda_drive),
      .scl_rise  (scl_rise),
      .busy      (bus_busy),
      .evt       (evt)
   );

   i2cmon_arb_check u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .own_master (own_master),
      .sda_drive  (sda_drive),
      .scl_rise   (scl_rise),
      .sda_f      (sda_f),
      .arb_lost   (arb_lost),
      .release_bus(release_bus)
   );

   assign ev_start  = evt.start;
   assign ev_rstart = evt.rstart;
   assign ev_stop   = evt.stop;
   assign bus_error = evt.error;
   assign wake_req  = evt.wake;

   AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_start, ev_rstart, ev_stop})); // R3
   AST_COLLIDE_NO_ARB: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_error && ev_rstart && $past(own_master)) |-> !arb_lost); // R8

endmodule

// File: tb/tb_i2c_bus_monitor.sv
module tb_i2c_bus_monitor;
   localparam int F = 4;
   localparam int W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_raw = 1'b1, sda_raw = 1'b1, sda_drive = 1'b1, own_master = 1'b0;
   logic ev_start, ev_rstart, ev_stop, bus_busy, bus_error, arb_lost, release_bus, wake_req;

   int n_start = 0, n_rstart = 0, n_stop = 0, n_err = 0, n_arb = 0, n_wake = 0;
   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   i2c_bus_monitor #(.FILT_CYC(F), .SYNC_STAGES(2), .FRAME_BITS(9)) dut (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
      .sda_drive(sda_drive), .own_master(own_master),
      .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
      .bus_busy(bus_busy), .bus_error(bus_error), .arb_lost(arb_lost),
      .release_bus(release_bus), .wake_req(wake_req)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         n_start  += int'(ev_start);
         n_rstart += int'(ev_rstart);
         n_stop   += int'(ev_stop);
         n_err    += int'(bus_error);
         n_arb    += int'(arb_lost);
         n_wake   += int'(wake_req);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic d);
      @(negedge clk);
      scl_raw = c;
      sda_raw = d;
      repeat (W) @(negedge clk);
   endtask

   task automatic send_bit(input logic v);
      step(1'b0, sda_raw);
      step(1'b0, v);
      step(1'b1, v);
   endtask

   task automatic legal_stop();
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
   endtask

   initial begin
      #1_500_000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int s0, r0, p0, e0, a0, w0;
      repeat (3) @(negedge clk);
      // R2: reset state
      check("R2 reset busy", int'(bus_busy), 0);
      check("R2 reset events", int'({ev_start, ev_rstart, ev_stop, bus_error, arb_lost, release_bus, wake_req}), 0);
      rst_n = 1'b1;
      repeat (W) @(negedge clk);

      // R1: glitch width sweep on SDA with SCL high
      for (int w = 1; w <= 6; w++) begin
         s0 = n_start; p0 = n_stop;
         @(negedge clk);
         sda_raw = 1'b0;
         repeat (w) @(negedge clk);
         sda_raw = 1'b1;
         repeat (3 * W) @(negedge clk);
         check($sformatf("R1 glitch w=%0d start", w), n_start - s0, (w >= F) ? 1 : 0);
         check($sformatf("R1 glitch w=%0d stop", w), n_stop - p0, (w >= F) ? 1 : 0);
         check($sformatf("R1 glitch w=%0d idle", w), int'(bus_busy), 0);
      end

      // R2 R4 R9: full frame then legal stop
      s0 = n_start; p0 = n_stop; e0 = n_err; w0 = n_wake;
      step(1'b1, 1'b0);
      check("R2 start pulse", n_start - s0, 1);
      check("R2 busy set", int'(bus_busy), 1);
      check("R9 wake on start", n_wake - w0, 1);
      for (int b = 0; b < 9; b++) send_bit(b[0]);
      legal_stop();
      check("R4 stop pulse", n_stop - p0, 1);
      check("R4 busy cleared", int'(bus_busy), 0);
      check("R7 no error at legal stop", n_err - e0, 0);

      // R3 R9: repeated start at frame boundary
      s0 = n_start; r0 = n_rstart; e0 = n_err; w0 = n_wake;
      step(1'b1, 1'b0);
      for (int b = 0; b < 9; b++) send_bit(1'b0);
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      check("R3 rstart pulse", n_rstart - r0, 1);
      check("R3 no plain start", n_start - s0, 1);
      check("R3 busy kept", int'(bus_busy), 1);
      check("R9 wake on rstart", n_wake - w0, 2);
      check("R7 legal rstart no error", n_err - e0, 0);
      legal_stop();

      // R7: stop placed at each frame position 1..10
      for (int p = 1; p <= 10; p++) begin
         e0 = n_err; p0 = n_stop;
         step(1'b1, 1'b0);
         for (int b = 1; b < p; b++) send_bit(1'b0);
         step(1'b0, 1'b0);
         step(1'b1, 1'b0);
         step(1'b1, 1'b1);
         check($sformatf("R7 stop at pos %0d error", p), n_err - e0, (p >= 2 && p <= 9) ? 1 : 0);
         check($sformatf("R7 stop at pos %0d reported", p), n_stop - p0, 1);
      end

      // R7: misplaced start mid-frame
      e0 = n_err; r0 = n_rstart;
      step(1'b1, 1'b0);
      send_bit(1'b1);
      send_bit(1'b1);
      step(1'b1, 1'b0);
      check("R7 misplaced start error", n_err - e0, 1);
      check("R7 misplaced start reported", n_rstart - r0, 1);
      legal_stop();
      check("R7 stop after rstart legal", n_err - e0, 1);

      // R6: arbitration loss as master
      a0 = n_arb;
      own_master = 1'b1;
      sda_drive = 1'b0;
      step(1'b1, 1'b0);
      sda_drive = 1'b1;
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      check("R6 arb lost once", n_arb - a0, 1);
      check("R6 release held", int'(release_bus), 1);
      send_bit(1'b0);
      check("R6 no second loss", n_arb - a0, 1);
      check("R6 release still held", int'(release_bus), 1);
      own_master = 1'b0;
      repeat (3) @(negedge clk);
      check("R6 release dropped", int'(release_bus), 0);
      legal_stop();

      // R6: matching levels, no loss
      a0 = n_arb;
      own_master = 1'b1;
      sda_drive = 1'b0;
      step(1'b1, 1'b0);
      for (int b = 0; b < 4; b++) begin
         sda_drive = b[0];
         send_bit(b[0]);
      end
      check("R6 matching levels no loss", n_arb - a0, 0);
      sda_drive = 1'b0;
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      sda_drive = 1'b1;
      step(1'b1, 1'b1);
      own_master = 1'b0;

      // R5: same mismatch without master role
      a0 = n_arb;
      step(1'b1, 1'b0);
      sda_drive = 1'b1;
      send_bit(1'b0);
      send_bit(1'b0);
      check("R5 no arb when not master", n_arb - a0, 0);
      check("R5 no release when not master", int'(release_bus), 0);
      legal_stop();

      // R8: foreign start while device releases a bit
      a0 = n_arb; e0 = n_err; r0 = n_rstart;
      own_master = 1'b1;
      sda_drive = 1'b0;
      step(1'b1, 1'b0);
      for (int b = 0; b < 9; b++) send_bit(1'b0);
      sda_drive = 1'b1;
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      check("R8 collision error", n_err - e0, 1);
      check("R8 collision rstart", n_rstart - r0, 1);
      check("R8 collision no arb", n_arb - a0, 0);
      own_master = 1'b0;
      legal_stop();
      check("R4 final idle", int'(bus_busy), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule